// File: doc/BRIEF.md
# Program Status Word Flag Update Unit

This block holds the carry, overflow and auxiliary (nibble) carry bits of an 8051-compatible processor's status word and decides, for each executed instruction, what happens to each of them. Every instruction class has a fixed policy for each flag. The flag can be left as it is, cleared, set, or loaded from a value the datapath or the boolean unit computes. The datapath supplies the results of its arithmetic, rotation, decimal adjust and compare. The block itself computes the single-bit boolean results of the carry-bit instructions.

An instruction takes effect only in a cycle where the execute strobe is high. A direct write to the status word takes priority over any instruction update in the same cycle. All three flags are registered and change on the rising clock edge after the cycle that caused the change.

The instruction class is a 5-bit code. Classes not listed below leave all flags unchanged. On the direct-write bus, bit 2 is carry, bit 1 is auxiliary carry and bit 0 is overflow.

Top module: `psw_flag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the carry, overflow and auxiliary carry outputs become 0 on that edge.
- R2: For class 1 (add), class 2 (add with carry) and class 3 (subtract with borrow), carry loads `alu_carry`, overflow loads `alu_ovf` and auxiliary carry loads `alu_half_carry`.
- R3: For class 4 (multiply) and class 5 (divide), carry is cleared, overflow loads `alu_ovf`, and auxiliary carry is unchanged.
- R4: For class 6 (decimal adjust), class 7 (rotate right through carry), class 8 (rotate left through carry) and class 17 (compare-and-jump), carry loads `alu_carry`, and overflow and auxiliary carry are unchanged.
- R5: Class 9 (set carry) makes carry 1 and class 10 (clear carry) makes carry 0. Neither class changes overflow or auxiliary carry.
- R6: For the boolean classes, carry becomes the value listed below and overflow and auxiliary carry are unchanged. Here b is `bit_operand` and C is the old carry.
  - Class 11 (complement): not C.
  - Class 12 (AND): C and b.
  - Class 13 (AND with inverted bit): C and not b.
  - Class 14 (OR): C or b.
  - Class 15 (OR with inverted bit): C or not b.
  - Class 16 (move): b.
- R7: Class 0, every class code of 18 or above, and any cycle with `instr_valid` low leave all three flags unchanged.
- R8: When `psw_wr_en` is high, the three flags take the values on `psw_wr_flags` (bit 2 carry, bit 1 auxiliary carry, bit 0 overflow). This holds whatever instruction is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Execute strobe; the instruction class is applied only when high |
| instr_class | input | 5 | Decoded instruction class code |
| alu_carry | input | 1 | Carry, borrow, rotated-out bit, decimal-adjust carry or compare result from the datapath |
| alu_ovf | input | 1 | Signed overflow result from the datapath |
| alu_half_carry | input | 1 | Carry out of the low nibble from the datapath |
| bit_operand | input | 1 | Bit operand for the boolean carry instructions |
| psw_wr_en | input | 1 | Direct write of the status word flags |
| psw_wr_flags | input | 3 | Direct-write data: bit 2 carry, bit 1 auxiliary carry, bit 0 overflow |
| cy | output | 1 | Registered carry flag |
| ac | output | 1 | Registered auxiliary carry flag |
| ov | output | 1 | Registered overflow flag |

## Verification
The assertions take for granted that `instr_class`, `instr_valid` and the datapath results are stable, known values at every rising edge. They also take for granted that a direct write is signalled only by `psw_wr_en`, never through the class code. The bench drives every input at the falling edge, so each value is settled half a period before the edge that samples it. The bench brings each flag to a known state through a direct write before every instruction scenario, so an unchanged flag can be told apart from one that was cleared or set. The override scenario is the only case where a direct write and an instruction are presented together.

// File: rtl/psw_flag_pkg.sv
package psw_flag_pkg;
  localparam int CLASS_W   = 5;
  localparam int NUM_FLAGS = 3;
  // index of each flag in the flag vector and in the direct-write bus
  localparam int F_CY = 2;
  localparam int F_AC = 1;
  localparam int F_OV = 0;

  typedef enum logic [CLASS_W-1:0] {
    IC_NONE    = 5'd0,
    IC_ADD     = 5'd1,
    IC_ADDC    = 5'd2,
    IC_SUBB    = 5'd3,
    IC_MUL     = 5'd4,
    IC_DIV     = 5'd5,
    IC_DA      = 5'd6,
    IC_RRC     = 5'd7,
    IC_RLC     = 5'd8,
    IC_SETC    = 5'd9,
    IC_CLRC    = 5'd10,
    IC_CPLC    = 5'd11,
    IC_ANDC    = 5'd12,
    IC_ANDC_N  = 5'd13,
    IC_ORC     = 5'd14,
    IC_ORC_N   = 5'd15,
    IC_MOVC    = 5'd16,
    IC_CMPJ    = 5'd17
  } instr_class_e;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_LOAD = 2'd3
  } flag_act_e;
endpackage

// File: rtl/psw_flag_policy.sv
module psw_flag_policy
  import psw_flag_pkg::*;
(
  input  logic                              valid,
  input  logic [CLASS_W-1:0]                cls,
  output flag_act_e [NUM_FLAGS-1:0]         act,
  output logic                              cy_from_bool
);
  always_comb begin
    act          = {NUM_FLAGS{ACT_KEEP}};
    cy_from_bool = 1'b0;
    if (valid) begin
      case (cls)
        IC_ADD, IC_ADDC, IC_SUBB: begin
          act[F_CY] = ACT_LOAD;
          act[F_AC] = ACT_LOAD;
          act[F_OV] = ACT_LOAD;
        end
        IC_MUL, IC_DIV: begin
          act[F_CY] = ACT_CLR;
          act[F_OV] = ACT_LOAD;
        end
        IC_DA, IC_RRC, IC_RLC, IC_CMPJ: act[F_CY] = ACT_LOAD;
        IC_SETC: act[F_CY] = ACT_SET;
        IC_CLRC: act[F_CY] = ACT_CLR;
        IC_CPLC, IC_ANDC, IC_ANDC_N, IC_ORC, IC_ORC_N, IC_MOVC: begin
          act[F_CY]    = ACT_LOAD;
          cy_from_bool = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/psw_bool_carry.sv
module psw_bool_carry
  import psw_flag_pkg::*;
(
  input  logic [CLASS_W-1:0] cls,
  input  logic               cy_now,
  input  logic               bit_in,
  output logic               bool_res
);
  logic bit_eff;

  always_comb begin
    bit_eff = ((cls == IC_ANDC_N) || (cls == IC_ORC_N)) ? ~bit_in : bit_in;
    case (cls)
      IC_CPLC:            bool_res = ~cy_now;
      IC_ANDC, IC_ANDC_N: bool_res = cy_now & bit_eff;
      IC_ORC, IC_ORC_N:   bool_res = cy_now | bit_eff;
      IC_MOVC:            bool_res = bit_eff;
      default:            bool_res = cy_now;
    endcase
  end
endmodule

// File: rtl/psw_flag_cell.sv
module psw_flag_cell
  import psw_flag_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_act_e act,
  input  logic      load_val,
  input  logic      wr_en,
  input  logic      wr_val,
  output logic      q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else if (wr_en) begin
      q <= wr_val;
    end else begin
      case (act)
        ACT_CLR:  q <= 1'b0;
        ACT_SET:  q <= 1'b1;
        ACT_LOAD: q <= load_val;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_flag_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [CLASS_W-1:0] instr_class,
  input  logic               alu_carry,
  input  logic               alu_ovf,
  input  logic               alu_half_carry,
  input  logic               bit_operand,
  input  logic               psw_wr_en,
  input  logic [NUM_FLAGS-1:0] psw_wr_flags,
  output logic               cy,
  output logic               ac,
  output logic               ov
);
  flag_act_e [NUM_FLAGS-1:0] act;
  logic                      cy_from_bool;
  logic                      bool_res;
  logic [NUM_FLAGS-1:0]      load_val;
  logic [NUM_FLAGS-1:0]      flags_q;

  psw_flag_policy u_policy (
    .valid        (instr_valid),
    .cls          (instr_class),
    .act          (act),
    .cy_from_bool (cy_from_bool)
  );

  psw_bool_carry u_bool (
    .cls      (instr_class),
    .cy_now   (flags_q[F_CY]),
    .bit_in   (bit_operand),
    .bool_res (bool_res)
  );

  always_comb begin
    load_val       = '0;
    load_val[F_CY] = cy_from_bool ? bool_res : alu_carry;
    load_val[F_AC] = alu_half_carry;
    load_val[F_OV] = alu_ovf;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    psw_flag_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .act      (act[i]),
      .load_val (load_val[i]),
      .wr_en    (psw_wr_en),
      .wr_val   (psw_wr_flags[i]),
      .q        (flags_q[i])
    );
  end

  assign cy = flags_q[F_CY];
  assign ac = flags_q[F_AC];
  assign ov = flags_q[F_OV];

  // ---------------- assertions ----------------
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> ({cy, ac, ov} == 3'b000));

  assert_arith_load_R2: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !psw_wr_en &&
     (instr_class == IC_ADD || instr_class == IC_ADDC || instr_class == IC_SUBB))
    |=> (cy == $past(alu_carry) && ac == $past(alu_half_carry) && ov == $past(alu_ovf)));

  assert_muldiv_R3: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !psw_wr_en && (instr_class == IC_MUL || instr_class == IC_DIV))
    |=> (!cy && ov == $past(alu_ovf) && ac == $past(ac)));

  assert_cy_only_R4: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !psw_wr_en &&
     (instr_class == IC_DA || instr_class == IC_RRC ||
      instr_class == IC_RLC || instr_class == IC_CMPJ))
    |=> (cy == $past(alu_carry) && $stable(ac) && $stable(ov)));

  assert_set_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !psw_wr_en && (instr_class == IC_SETC || instr_class == IC_CLRC))
    |=> (cy == ($past(instr_class) == IC_SETC) && $stable(ac) && $stable(ov)));

  assert_bool_side_R6: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !psw_wr_en && instr_class >= IC_CPLC && instr_class <= IC_MOVC)
    |=> ($stable(ac) && $stable(ov)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!psw_wr_en && (!instr_valid || instr_class == IC_NONE || instr_class > IC_CMPJ))
    |=> $stable({cy, ac, ov}));

  assert_direct_wins_R8: assert property (@(posedge clk) disable iff (rst)
    psw_wr_en |=> ({cy, ac, ov} == $past(psw_wr_flags)));
endmodule

// File: tb/psw_flag_unit_tb.sv
module psw_flag_unit_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       instr_valid;
  logic [4:0] instr_class;
  logic       alu_carry, alu_ovf, alu_half_carry, bit_operand;
  logic       psw_wr_en;
  logic [2:0] psw_wr_flags;
  logic       cy, ac, ov;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  psw_flag_unit u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_class(instr_class),
    .alu_carry(alu_carry), .alu_ovf(alu_ovf), .alu_half_carry(alu_half_carry),
    .bit_operand(bit_operand), .psw_wr_en(psw_wr_en), .psw_wr_flags(psw_wr_flags),
    .cy(cy), .ac(ac), .ov(ov)
  );

  // expected is {cy, ac, ov}
  task automatic chk(input string req, input logic [2:0] exp);
    checks++;
    if ({cy, ac, ov} !== exp) begin
      errors++;
      $display("FAIL %s: got cy/ac/ov=%b expected %b", req, {cy, ac, ov}, exp);
    end
  endtask

  task automatic idle_inputs();
    instr_valid = 1'b0; instr_class = 5'd0; alu_carry = 1'b0; alu_ovf = 1'b0;
    alu_half_carry = 1'b0; bit_operand = 1'b0; psw_wr_en = 1'b0; psw_wr_flags = 3'b000;
  endtask

  task automatic preset(input logic [2:0] f);
    @(negedge clk);
    idle_inputs();
    psw_wr_en = 1'b1; psw_wr_flags = f;
    @(posedge clk); #1;
    psw_wr_en = 1'b0;
  endtask

  task automatic exec(input logic [4:0] c, input logic car, input logic ovf,
                      input logic half, input logic b);
    @(negedge clk);
    idle_inputs();
    instr_valid = 1'b1; instr_class = c; alu_carry = car; alu_ovf = ovf;
    alu_half_carry = half; bit_operand = b;
    @(posedge clk); #1;
    instr_valid = 1'b0;
  endtask

  task automatic t_reset();
    preset(3'b111);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    chk("R1", 3'b000);
  endtask

  task automatic t_arith();
    preset(3'b000); exec(5'd1, 1, 0, 1, 0); chk("R2 add", 3'b110);
    preset(3'b111); exec(5'd2, 0, 1, 0, 1); chk("R2 addc", 3'b001);
    preset(3'b010); exec(5'd3, 1, 1, 0, 0); chk("R2 subb", 3'b101);
  endtask

  task automatic t_muldiv();
    preset(3'b110); exec(5'd4, 1, 1, 0, 0); chk("R3 mul", 3'b011);
    preset(3'b101); exec(5'd5, 1, 0, 1, 1); chk("R3 div", 3'b000);
  endtask

  task automatic t_cy_only();
    preset(3'b011); exec(5'd6, 1, 0, 0, 0); chk("R4 da", 3'b111);
    preset(3'b100); exec(5'd7, 0, 1, 1, 0); chk("R4 rrc", 3'b000);
    preset(3'b010); exec(5'd8, 1, 1, 0, 0); chk("R4 rlc", 3'b110);
    preset(3'b101); exec(5'd17, 0, 0, 1, 1); chk("R4 cmpj", 3'b001);
  endtask

  task automatic t_set_clr();
    preset(3'b010); exec(5'd9, 0, 1, 0, 0); chk("R5 set", 3'b110);
    preset(3'b101); exec(5'd10, 1, 0, 1, 1); chk("R5 clr", 3'b001);
  endtask

  task automatic t_bool();
    preset(3'b011); exec(5'd11, 0, 0, 0, 0); chk("R6 cpl", 3'b111);
    preset(3'b100); exec(5'd12, 1, 1, 1, 1); chk("R6 and", 3'b100);
    preset(3'b100); exec(5'd12, 1, 1, 1, 0); chk("R6 and b0", 3'b000);
    preset(3'b101); exec(5'd13, 0, 0, 0, 0); chk("R6 and-not", 3'b101);
    preset(3'b110); exec(5'd13, 0, 0, 0, 1); chk("R6 and-not b1", 3'b010);
    preset(3'b000); exec(5'd14, 0, 0, 0, 1); chk("R6 or", 3'b100);
    preset(3'b001); exec(5'd15, 0, 0, 0, 1); chk("R6 or-not b1", 3'b001);
    preset(3'b010); exec(5'd15, 0, 0, 0, 0); chk("R6 or-not b0", 3'b110);
    preset(3'b111); exec(5'd16, 1, 0, 0, 0); chk("R6 mov", 3'b011);
  endtask

  task automatic t_unlisted();
    preset(3'b101); exec(5'd0, 0, 1, 1, 1); chk("R7 class0", 3'b101);
    preset(3'b010); exec(5'd18, 1, 1, 0, 1); chk("R7 class18", 3'b010);
    preset(3'b110); exec(5'd31, 0, 0, 1, 0); chk("R7 class31", 3'b110);
    preset(3'b011);
    @(negedge clk); idle_inputs(); instr_class = 5'd9; alu_carry = 1'b1;
    @(posedge clk); #1;
    chk("R7 strobe low", 3'b011);
  endtask

  task automatic t_override();
    preset(3'b000);
    @(negedge clk); idle_inputs();
    instr_valid = 1'b1; instr_class = 5'd9; psw_wr_en = 1'b1; psw_wr_flags = 3'b010;
    @(posedge clk); #1;
    chk("R8 vs set", 3'b010);
    @(negedge clk); idle_inputs();
    instr_valid = 1'b1; instr_class = 5'd1; alu_carry = 1'b1; alu_ovf = 1'b1;
    alu_half_carry = 1'b1; psw_wr_en = 1'b1; psw_wr_flags = 3'b001;
    @(posedge clk); #1;
    chk("R8 vs add", 3'b001);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 initial", 3'b000);
    rst = 1'b0;
    t_reset();
    t_arith();
    t_muldiv();
    t_cy_only();
    t_set_clr();
    t_bool();
    t_unlisted();
    t_override();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule